// File: doc/BRIEF.md
# Input change interrupt generator

This block raises an interrupt request whenever a pin set up as an input no longer matches the level it had when software last sampled the input port. It keeps a snapshot of every pin and compares the live, already synchronized pin levels against that snapshot. Pins set up as outputs take no part in the comparison.

The request is level based and is not latched. If a changed pin returns to its snapshot level, the request drops by itself. A one-cycle read pulse from the register interface reloads the snapshot from the pins, and that also clears the request. The output enables an open-drain pull-down: a 1 pulls the shared active-low interrupt line low. The output is registered, so it follows the compare result by one clock edge. With any system clock above 1 MHz, both assertion and release complete well inside 4 µs.

Top module: `pin_change_irq`

## Requirements
- R1: In the reset cycle the snapshot loads the current pin levels, and `irq_pd_o` is 0. While reset is low, and after it ends, `irq_pd_o` stays 0 until a pin changes.
- R2: When any pin whose `dir_in_i` bit is 1 (input) differs from its snapshot bit, `irq_pd_o` is 1 after the next rising clock edge. The latency is exactly one edge.
- R3: When every input pin again matches its snapshot, `irq_pd_o` returns to 0 after the next edge, with no read pulse needed.
- R4: When `rd_pulse_i` is 1 at an edge, the snapshot reloads from `pins_i` and `irq_pd_o` is 0 after that edge. It stays 0 afterwards while the pins hold those levels.
- R5: A pin whose `dir_in_i` bit is 0 (output) never causes the request, whatever its level.
- R6: When a pin is switched from output (0) to input (1) while its level differs from the snapshot, `irq_pd_o` becomes 1 one edge later.
- R7: The request stays 1 as long as at least one input pin differs from the snapshot, even after other differing pins have returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | WIDTH | Synchronized pin levels (raw, not inverted) |
| dir_in_i | input | WIDTH | Direction per pin, 1 = input, 0 = output |
| rd_pulse_i | input | 1 | One-cycle pulse when the input port register is read |
| irq_pd_o | output | 1 | Interrupt pull-down enable, 1 drives the active-low line low |

## Verification
The assertions assume that `pins_i` and `dir_in_i` are already synchronous to `clk`, and that `rd_pulse_i` lasts a single cycle. The bench changes every input only on falling edges and raises the read pulse for exactly one cycle. The embedded properties also assume that reset is held low across at least one rising edge before it is released. The bench keeps reset low for three edges.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] dir_in_i,
  input  logic             rd_pulse_i,
  output logic             irq_pd_o
);

  logic [WIDTH-1:0] snap_q;
  logic             irq_q;
  logic [WIDTH-1:0] diff;

  assign diff     = (pins_i ^ snap_q) & dir_in_i;
  assign irq_pd_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= pins_i;
      irq_q  <= 1'b0;
    end else if (rd_pulse_i) begin
      snap_q <= pins_i;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= |diff;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !irq_pd_o); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse_i |=> !irq_pd_o); // R4
  AST_OUTPUTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in_i == '0) |=> !irq_pd_o); // R5
  AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pd_o) |-> $past(|dir_in_i)); // R2

endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hA5;
  logic [7:0] dir = 8'hFF;
  logic       rd = 1'b0;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  pin_change_irq #(.WIDTH(8)) u_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .dir_in_i(dir),
    .rd_pulse_i(rd), .irq_pd_o(irq)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_pd_o=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) step();
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    step(); check(1'b0, "R1 after reset");
    step(); check(1'b0, "R1 steady");
  endtask

  task automatic t_change_return();
    pins = 8'hA4;
    step(); check(1'b1, "R2 single input change");
    pins = 8'hA5;
    step(); check(1'b0, "R3 pin returned");
  endtask

  task automatic t_read();
    pins = 8'h5A;
    step(); check(1'b1, "R2 many bits changed");
    rd = 1'b1;
    step(); check(1'b0, "R4 read clears");
    rd = 1'b0;
    step(); check(1'b0, "R4 snapshot reloaded");
    step(); check(1'b0, "R4 stays clear");
  endtask

  task automatic t_outputs_switch();
    dir = 8'h0F;
    pins = 8'hAA;
    step(); check(1'b0, "R5 output pins toggled");
    step(); check(1'b0, "R5 still quiet");
    dir = 8'hFF;
    step(); check(1'b1, "R6 output to input with mismatch");
    pins = 8'h5A;
    step(); check(1'b0, "R3 mismatch removed");
  endtask

  task automatic t_multi();
    pins = 8'hDB;
    step(); check(1'b1, "R7 two pins differ");
    pins = 8'hDA;
    step(); check(1'b1, "R7 one still differs");
    pins = 8'h5A;
    step(); check(1'b0, "R7 all returned");
  endtask

  initial begin
    t_reset();
    t_change_return();
    t_read();
    t_outputs_switch();
    t_multi();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule